// File: doc/BRIEF.md
# Floating-Point Status Word Unit

This block keeps the 16-bit status word of a floating-point execution unit. Each cycle the execution pipeline may present event pulses: six arithmetic exception events, a register-stack fault together with its direction, a rounding-direction indication for inexact results, the outcome of a partial-remainder step, the outcome of a trigonometric range test, a generic condition-code update and a new top-of-stack index. The block folds these events into the word. Exception flags and the stack-fault flag are sticky and stay set until a command removes them.

Three commands act on the word: clear-exceptions, initialize, and a full load from an external 14-bit image. An exception mask from the control register decides whether a raised flag also raises the error summary. The summary is driven out as the request for an exception handler and is also copied into a compatibility bit at the top of the word. Condition-code bit C1 has several sources, and a fixed priority chooses among them.

Top module: `fpsw_top`

## Requirements
- R1: After reset `statusWord` is 16'h0000 and `errSummary` is 0. Field positions: bit 0 invalid (IE), 1 denormal (DE), 2 divide-by-zero (ZE), 3 overflow (OE), 4 underflow (UE), 5 precision (PE), 6 stack fault (SF), 7 error summary (ES), 8 C0, 9 C1, 10 C2, 13:11 TOP, 14 C3, 15 busy mirror (B). `excEvt` and `excMask` use bit positions 0 to 5 in that same order.
- R2: Flags in bits 0 to 6 are sticky. Once set, a bit stays set until a clear, an initialize or a load.
- R3: ES is 1 exactly when some flag in bits 0 to 5 is set and its `excMask` bit is 0. A masked event still sets its flag. ES and `errSummary` follow a change of `excMask` in the same cycle, without a clock edge.
- R4: Bit 15 always equals ES.
- R5: A `stackFault` pulse sets SF and IE and writes C1 = `stackOverflow` (1 for overflow, 0 for underflow).
- R6: A precision event (`excEvt[5]`) writes C1 = `roundUp`. If a stack fault arrives in the same cycle, the stack-fault value of C1 takes priority.
- R7: When `remDone` is high and `remComplete` is 1, the block writes C2 = 0, C0 = `remQuot[2]`, C3 = `remQuot[1]` and C1 = `remQuot[0]` (C1 only if no stack fault or precision event arrives in the same cycle). When `remDone` is high and `remComplete` is 0, it writes C2 = 1 and leaves C0, C1 and C3 unchanged.
- R8: A `rangeEvt` pulse without `remDone` writes C2 = `rangeOut`.
- R9: `ccWrite` loads C0 to C3 from `ccIn[0]` to `ccIn[3]`. Any specific source for a bit (stack fault, rounding, remainder, range) overrides `ccIn` for that bit. `topWrite` loads TOP from `topIn`.
- R10: `clrExc` zeroes bits 0 to 7 and bit 15 and leaves the condition codes and TOP unchanged.
- R11: `initCmd` zeroes the whole word.
- R12: `loadCmd` writes bits 6:0 from `loadFlags` and bits 14:8 from `loadUpper`. ES and B are then recomputed from the loaded flags and the current mask.
- R13: In a cycle with any command, all events are dropped. Priority among commands is initialize, then load, then clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excEvt | input | 6 | Exception event pulses, IE..PE |
| roundUp | input | 1 | Last rounding went upward (used with PE event) |
| stackFault | input | 1 | Register-stack fault pulse |
| stackOverflow | input | 1 | Fault direction: 1 overflow, 0 underflow |
| remDone | input | 1 | Partial-remainder step finished |
| remComplete | input | 1 | 1 when the reduction is complete |
| remQuot | input | 3 | Low quotient bits Q2..Q0 |
| rangeEvt | input | 1 | Trigonometric range test done |
| rangeOut | input | 1 | Operand out of range |
| ccWrite | input | 1 | Generic condition-code update |
| ccIn | input | 4 | New C3..C0 |
| topWrite | input | 1 | Top-of-stack update |
| topIn | input | 3 | New TOP value |
| excMask | input | 6 | Exception mask, 1 = masked |
| clrExc | input | 1 | Clear-exceptions command |
| initCmd | input | 1 | Initialize command |
| loadCmd | input | 1 | Full-load command |
| loadFlags | input | 7 | Image of word bits 6:0 |
| loadUpper | input | 7 | Image of word bits 14:8 |
| statusWord | output | 16 | Assembled status word |
| errSummary | output | 1 | Error summary, requests the handler |

## Verification
The bench walks a vector table in which each cycle combines sources that compete for the same bit. A stack fault paired with an upward rounding shows whether the C1 priority holds. A generic update paired with a complete remainder shows whether the specific sources override it. A complete and an incomplete reduction are applied in turn, with range tests before and after, so the C2 writes can be distinguished. Mask-only steps with no event show that the summary follows the mask without a clock edge. Loads and initializes applied together with events show that commands drop those events. Directed steps then check the reset word, flags that persist through idle cycles, and a reset in the middle of operation.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
  localparam int EXC_N  = 6;
  localparam int TOP_W  = 3;
  localparam int CC_N   = 4;
  localparam int QUOT_W = 3;
  localparam int WORD_W = 16;
  localparam int FLAG_N = EXC_N + 1;           // exceptions plus stack fault
  localparam int UPPER_N = CC_N + TOP_W;       // bits 14:8 of the word

  typedef enum logic [2:0] {
    C1_KEEP, C1_FAULT, C1_ROUND, C1_QUOT, C1_CC
  } c1Sel_e;

  typedef enum logic [1:0] {
    C2_KEEP, C2_QUOT, C2_RANGE, C2_CC
  } c2Sel_e;

  typedef enum logic [1:0] {
    C03_KEEP, C03_QUOT, C03_CC
  } c03Sel_e;

  typedef struct packed {
    logic    init;
    logic    load;
    logic    clear;
    logic    capture;
    logic    topWr;
    c1Sel_e  c1Sel;
    c2Sel_e  c2Sel;
    c03Sel_e c03Sel;
  } swStrobe_t;
endpackage

// File: rtl/fpsw_ctrl.sv
module fpsw_ctrl
  import fpsw_pkg::*;
(
  input  logic      initCmd,
  input  logic      loadCmd,
  input  logic      clrExc,
  input  logic      stackFault,
  input  logic      precisionEvt,
  input  logic      remDone,
  input  logic      remComplete,
  input  logic      rangeEvt,
  input  logic      ccWrite,
  input  logic      topWrite,
  output swStrobe_t strobe
);
  logic evtOk;

  // R13: init beats load beats clear; any command drops the events
  assign evtOk = !(initCmd || loadCmd || clrExc);

  always_comb begin
    strobe         = '0;
    strobe.init    = initCmd;
    strobe.load    = loadCmd && !initCmd;
    strobe.clear   = clrExc && !loadCmd && !initCmd;
    strobe.capture = evtOk;
    strobe.topWr   = evtOk && topWrite;
    strobe.c1Sel   = C1_KEEP;
    strobe.c2Sel   = C2_KEEP;
    strobe.c03Sel  = C03_KEEP;
    if (evtOk) begin
      // R6: stack fault outranks rounding, which outranks the quotient
      if (stackFault)                  strobe.c1Sel = C1_FAULT;
      else if (precisionEvt)           strobe.c1Sel = C1_ROUND;
      else if (remDone && remComplete) strobe.c1Sel = C1_QUOT;
      else if (ccWrite)                strobe.c1Sel = C1_CC;

      if (remDone)       strobe.c2Sel = C2_QUOT;
      else if (rangeEvt) strobe.c2Sel = C2_RANGE;
      else if (ccWrite)  strobe.c2Sel = C2_CC;

      if (remDone && remComplete) strobe.c03Sel = C03_QUOT;
      else if (ccWrite)           strobe.c03Sel = C03_CC;
    end
  end
endmodule

// File: rtl/fpsw_datapath.sv
module fpsw_datapath
  import fpsw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  swStrobe_t          strobe,
  input  logic [EXC_N-1:0]   excEvt,
  input  logic               stackFault,
  input  logic               stackOverflow,
  input  logic               roundUp,
  input  logic               remComplete,
  input  logic [QUOT_W-1:0]  remQuot,
  input  logic               rangeOut,
  input  logic [CC_N-1:0]    ccIn,
  input  logic [TOP_W-1:0]   topIn,
  input  logic [FLAG_N-1:0]  loadFlags,
  input  logic [UPPER_N-1:0] loadUpper,
  output logic [EXC_N-1:0]   excFlags,
  output logic               sfFlag,
  output logic [CC_N-1:0]    ccReg,      // index n holds Cn
  output logic [TOP_W-1:0]   topReg
);
  logic [EXC_N-1:0] faultAsIe;

  assign faultAsIe = EXC_N'(stackFault); // stack fault raises invalid (bit 0)

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excFlags <= '0;
      sfFlag   <= 1'b0;
      ccReg    <= '0;
      topReg   <= '0;
    end else if (strobe.init) begin
      excFlags <= '0;
      sfFlag   <= 1'b0;
      ccReg    <= '0;
      topReg   <= '0;
    end else if (strobe.load) begin
      excFlags <= loadFlags[EXC_N-1:0];
      sfFlag   <= loadFlags[EXC_N];
      ccReg[0] <= loadUpper[0];
      ccReg[1] <= loadUpper[1];
      ccReg[2] <= loadUpper[2];
      topReg   <= loadUpper[3 +: TOP_W];
      ccReg[3] <= loadUpper[UPPER_N-1];
    end else begin
      if (strobe.clear) begin
        excFlags <= '0;
        sfFlag   <= 1'b0;
      end else if (strobe.capture) begin
        excFlags <= excFlags | excEvt | faultAsIe;
        sfFlag   <= sfFlag | stackFault;
      end

      if (strobe.topWr) topReg <= topIn;

      unique case (strobe.c1Sel)
        C1_FAULT: ccReg[1] <= stackOverflow;
        C1_ROUND: ccReg[1] <= roundUp;
        C1_QUOT:  ccReg[1] <= remQuot[0];
        C1_CC:    ccReg[1] <= ccIn[1];
        default:  ;
      endcase

      unique case (strobe.c2Sel)
        C2_QUOT:  ccReg[2] <= !remComplete;
        C2_RANGE: ccReg[2] <= rangeOut;
        C2_CC:    ccReg[2] <= ccIn[2];
        default:  ;
      endcase

      unique case (strobe.c03Sel)
        C03_QUOT: begin
          ccReg[0] <= remQuot[2];
          ccReg[3] <= remQuot[1];
        end
        C03_CC: begin
          ccReg[0] <= ccIn[0];
          ccReg[3] <= ccIn[3];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpsw_summary.sv
module fpsw_summary
  import fpsw_pkg::*;
(
  input  logic [EXC_N-1:0] excFlags,
  input  logic [EXC_N-1:0] excMask,
  output logic             summary
);
  logic [EXC_N-1:0] liveHit;

  for (genvar i = 0; i < EXC_N; i++) begin : g_hit
    assign liveHit[i] = excFlags[i] && !excMask[i];
  end

  assign summary = |liveHit;
endmodule

// File: rtl/fpsw_top.sv
module fpsw_top
  import fpsw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [EXC_N-1:0]   excEvt,
  input  logic               roundUp,
  input  logic               stackFault,
  input  logic               stackOverflow,
  input  logic               remDone,
  input  logic               remComplete,
  input  logic [QUOT_W-1:0]  remQuot,
  input  logic               rangeEvt,
  input  logic               rangeOut,
  input  logic               ccWrite,
  input  logic [CC_N-1:0]    ccIn,
  input  logic               topWrite,
  input  logic [TOP_W-1:0]   topIn,
  input  logic [EXC_N-1:0]   excMask,
  input  logic               clrExc,
  input  logic               initCmd,
  input  logic               loadCmd,
  input  logic [FLAG_N-1:0]  loadFlags,
  input  logic [UPPER_N-1:0] loadUpper,
  output logic [WORD_W-1:0]  statusWord,
  output logic               errSummary
);
  swStrobe_t        strobe;
  logic [EXC_N-1:0] excFlags;
  logic             sfFlag;
  logic [CC_N-1:0]  ccReg;
  logic [TOP_W-1:0] topReg;
  logic             esBit;

  fpsw_ctrl u_ctrl (
    .initCmd      (initCmd),
    .loadCmd      (loadCmd),
    .clrExc       (clrExc),
    .stackFault   (stackFault),
    .precisionEvt (excEvt[EXC_N-1]),
    .remDone      (remDone),
    .remComplete  (remComplete),
    .rangeEvt     (rangeEvt),
    .ccWrite      (ccWrite),
    .topWrite     (topWrite),
    .strobe       (strobe)
  );

  fpsw_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .excEvt        (excEvt),
    .stackFault    (stackFault),
    .stackOverflow (stackOverflow),
    .roundUp       (roundUp),
    .remComplete   (remComplete),
    .remQuot       (remQuot),
    .rangeOut      (rangeOut),
    .ccIn          (ccIn),
    .topIn         (topIn),
    .loadFlags     (loadFlags),
    .loadUpper     (loadUpper),
    .excFlags      (excFlags),
    .sfFlag        (sfFlag),
    .ccReg         (ccReg),
    .topReg        (topReg)
  );

  fpsw_summary u_sum (
    .excFlags (excFlags),
    .excMask  (excMask),
    .summary  (esBit)
  );

  assign statusWord = {esBit, ccReg[3], topReg, ccReg[2], ccReg[1], ccReg[0],
                       esBit, sfFlag, excFlags};
  assign errSummary = esBit;
endmodule

// File: rtl/fpsw_checker.sv
module fpsw_checker
  import fpsw_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               initCmd,
  input logic               loadCmd,
  input logic               clrExc,
  input logic               stackFault,
  input logic               stackOverflow,
  input logic [EXC_N-1:0]   excMask,
  input logic [UPPER_N-1:0] loadUpper,
  input logic [WORD_W-1:0]  statusWord,
  input logic               errSummary
);
  logic noCmd;
  assign noCmd = !(initCmd || loadCmd || clrExc);

  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    noCmd |=> ((statusWord[6:0] & $past(statusWord[6:0])) == $past(statusWord[6:0])));

  a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (excMask == '1) |-> !errSummary);

  a_r5_fault_marks: assert property (@(posedge clk) disable iff (!rstN)
    (stackFault && noCmd) |=> (statusWord[6] && statusWord[0] &&
                               (statusWord[9] == $past(stackOverflow))));

  a_r10_clear_keeps_cc: assert property (@(posedge clk) disable iff (!rstN)
    (clrExc && !initCmd && !loadCmd) |=> ((statusWord[7:0] == 8'h00) && !statusWord[15] &&
                                         (statusWord[14:8] == $past(statusWord[14:8]))));

  a_r11_init_zero: assert property (@(posedge clk) disable iff (!rstN)
    initCmd |=> (statusWord == '0));

  a_r12_load_upper: assert property (@(posedge clk) disable iff (!rstN)
    (loadCmd && !initCmd) |=> (statusWord[14:8] == $past(loadUpper)));
endmodule

bind fpsw_top fpsw_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .initCmd       (initCmd),
  .loadCmd       (loadCmd),
  .clrExc        (clrExc),
  .stackFault    (stackFault),
  .stackOverflow (stackOverflow),
  .excMask       (excMask),
  .loadUpper     (loadUpper),
  .statusWord    (statusWord),
  .errSummary    (errSummary)
);

// File: tb/fpsw_top_bench.sv
`timescale 1ns/1ps
module fpsw_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  excEvt = '0;
  logic        roundUp = 1'b0, stackFault = 1'b0, stackOverflow = 1'b0;
  logic        remDone = 1'b0, remComplete = 1'b0;
  logic [2:0]  remQuot = '0;
  logic        rangeEvt = 1'b0, rangeOut = 1'b0, ccWrite = 1'b0;
  logic [3:0]  ccIn = '0;
  logic        topWrite = 1'b0;
  logic [2:0]  topIn = '0;
  logic [5:0]  excMask = 6'h3F;
  logic        clrExc = 1'b0, initCmd = 1'b0, loadCmd = 1'b0;
  logic [6:0]  loadFlags = '0, loadUpper = '0;
  logic [15:0] statusWord;
  logic        errSummary;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  fpsw_top u_fpsw_top (.*);

  typedef struct packed {
    logic [5:0]  exc;
    logic        ru, sf, sfOv, rem, remCmp;
    logic [2:0]  q;
    logic        rng, rngOut, ccW;
    logic [3:0]  cc;
    logic        topW;
    logic [2:0]  top;
    logic [5:0]  mask;
    logic        clr, init, load;
    logic [6:0]  ldF, ldU;
    logic [15:0] expWord;
    logic        expErr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  //             exc    ru sf ov rm rc q      rg ro cw cc      tw top    mask   cl in ld ldF    ldU    expWord   err req
  localparam vec_t TABLE [NV] = '{
    '{6'h02, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h0002, 0, 8'd3},  // R3 masked DE
    '{6'h00, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3D, 0, 0, 0, 7'h00, 7'h00, 16'h8082, 1, 8'd4},  // R3/R4 unmask DE
    '{6'h20, 1, 0, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h0222, 0, 8'd6},  // R6 round up
    '{6'h20, 1, 1, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h0063, 0, 8'd5},  // R5/R6 fault wins C1
    '{6'h00, 0, 0, 0, 0, 0, 3'd0, 0, 0, 1, 4'h9, 1, 3'd5, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h6963, 0, 8'd9},  // R9 cc and top
    '{6'h00, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 1, 0, 0, 7'h00, 7'h00, 16'h6900, 0, 8'd10}, // R10 clear
    '{6'h00, 0, 0, 0, 1, 1, 3'd5, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h2B00, 0, 8'd7},  // R7 complete
    '{6'h00, 0, 0, 0, 1, 0, 3'd2, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h2F00, 0, 8'd7},  // R7 incomplete
    '{6'h00, 0, 0, 0, 0, 0, 3'd0, 1, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h2B00, 0, 8'd8},  // R8 in range
    '{6'h00, 0, 1, 0, 0, 0, 3'd0, 1, 1, 0, 4'h0, 0, 3'd0, 6'h3E, 0, 0, 0, 7'h00, 7'h00, 16'hADC1, 1, 8'd8},  // R8 out, R5 underflow
    '{6'h00, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 1, 7'h3C, 7'h7F, 16'h7F3C, 0, 8'd12}, // R12 load
    '{6'h00, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3B, 0, 0, 0, 7'h00, 7'h00, 16'hFFBC, 1, 8'd3},  // R3 mask after load
    '{6'h3F, 1, 1, 1, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 0, 1, 7'h01, 7'h00, 16'h0001, 0, 8'd13}, // R13 load drops events
    '{6'h01, 0, 1, 1, 0, 0, 3'd0, 0, 0, 0, 4'h0, 0, 3'd0, 6'h3F, 0, 1, 1, 7'h7F, 7'h7F, 16'h0000, 0, 8'd11}, // R11 init over load
    '{6'h00, 0, 0, 0, 1, 1, 3'd2, 0, 0, 1, 4'h6, 0, 3'd0, 6'h3F, 0, 0, 0, 7'h00, 7'h00, 16'h4000, 0, 8'd9},  // R9/R7 quotient overrides cc
    '{6'h08, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 4'h0, 1, 3'd7, 6'h3F, 1, 0, 0, 7'h00, 7'h00, 16'h4000, 0, 8'd13}  // R13 clear drops events
  };

  task automatic checkWord(input logic [15:0] expW, input logic expE, input int req);
    applied++;
    if (statusWord !== expW) begin
      miscompares++;
      $display("FAIL R%0d statusWord actual %h expected %h", req, statusWord, expW);
    end
    applied++;
    if (errSummary !== expE) begin
      miscompares++;
      $display("FAIL R%0d errSummary actual %b expected %b", req, errSummary, expE);
    end
  endtask

  task automatic idleInputs();
    excEvt = '0; roundUp = 0; stackFault = 0; stackOverflow = 0;
    remDone = 0; remComplete = 0; remQuot = '0; rangeEvt = 0; rangeOut = 0;
    ccWrite = 0; ccIn = '0; topWrite = 0; topIn = '0;
    clrExc = 0; initCmd = 0; loadCmd = 0; loadFlags = '0; loadUpper = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset value
    checkWord(16'h0000, 1'b0, 1);
    rstN = 1'b1;
    @(negedge clk);
    checkWord(16'h0000, 1'b0, 1);

    for (int i = 0; i < NV; i++) begin
      excEvt = TABLE[i].exc; roundUp = TABLE[i].ru;
      stackFault = TABLE[i].sf; stackOverflow = TABLE[i].sfOv;
      remDone = TABLE[i].rem; remComplete = TABLE[i].remCmp; remQuot = TABLE[i].q;
      rangeEvt = TABLE[i].rng; rangeOut = TABLE[i].rngOut;
      ccWrite = TABLE[i].ccW; ccIn = TABLE[i].cc;
      topWrite = TABLE[i].topW; topIn = TABLE[i].top;
      excMask = TABLE[i].mask;
      clrExc = TABLE[i].clr; initCmd = TABLE[i].init; loadCmd = TABLE[i].load;
      loadFlags = TABLE[i].ldF; loadUpper = TABLE[i].ldU;
      @(negedge clk);
      checkWord(TABLE[i].expWord, TABLE[i].expErr, int'(TABLE[i].req));
    end
    idleInputs();

    // R2: overflow flag persists through idle cycles
    excMask = 6'h3F;
    excEvt = 6'h08;
    @(negedge clk);
    idleInputs();
    repeat (5) @(negedge clk);
    checkWord(16'h4008, 1'b0, 2);
    // R3: unmasking OE raises summary immediately, no edge needed
    excMask = 6'h37;
    #1;
    checkWord(16'hC088, 1'b1, 3);
    excMask = 6'h3F;

    // R1: reset mid-run returns the word to zero
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkWord(16'h0000, 1'b0, 1);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule